// File: doc/BRIEF.md
# Bus Request Legality Checker for a Register Slave

This block sits between the request channel of a TL-UL device port and a small register file. For each accepted request it decides, within the acceptance cycle, whether the request is legal. It checks bus protocol rules (opcode, size, byte-lane mask and address alignment) and device rules (mapped address, full-word CSR writes, and access direction per region). Only a legal request raises a read or write strobe towards the register file. Every accepted request, legal or not, gets exactly one response on the D channel, with the error bit set when any rule was broken.

The register map is built in and sized by parameters. Word indices `[0, NUM_RW)` are read/write. The next `NUM_RO` words are read-only. The `NUM_WO` words after those are write-only. Every higher index is unmapped. The register contents live outside the block: the block presents a word index, write data and strobes, and takes back the read word in the same cycle.

Only one transaction may be outstanding. While a response waits on a host that is not ready, new requests are held off.

Top module: `tlchk_dev`

## Requirements
- R1: A request whose opcode is not Get (4), PutFullData (0) or PutPartialData (1) is answered with `d_error`=1, raises no strobe, and gets `d_opcode` 0.
- R2: A PutFullData request whose mask is not exactly the lane set implied by its size and address is answered with an error and raises no strobe.
- R3: A mask with a byte lane outside the window set by the size and the address bits [1:0] is an error. Size 0 selects lane `addr[1:0]`, size 1 selects lanes 1:0 or 3:2 by `addr[1]`, and size 2 selects all four lanes.
- R4: An address that is not aligned to the transfer size (size 1 with `addr[0]`=1, or size 2 with `addr[1:0]`≠0), or a size of 3, is an error.
- R5: A request whose word index `addr[ADDR_W-1:2]` is at or above `NUM_RW+NUM_RO+NUM_WO` is answered with an error.
- R6: A write (either put opcode) with `addr[1:0]`≠0 or a mask other than 4'b1111 is an error.
- R7: A write to a read-only word and a read of a write-only word are both errors.
- R8: A legal accepted request pulses `reg_we` (puts) or `reg_re` (Get) in its acceptance cycle. An erroneous or non-accepted request pulses neither strobe, so no register changes.
- R9: The response is valid in the cycle after acceptance. `d_opcode` is 1 for Get and 0 otherwise. `d_source` and `d_size` echo the request.
- R10: A legal Get of any size and lane mask returns the full 32-bit register word. Any erroneous request, and any put, returns zero data.
- R11: While `d_valid` is 1 and `d_ready` is 0, `a_ready` is 0 and the response is held unchanged. A request presented in the cycle the response is taken is accepted back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Request valid |
| a_ready | output | 1 | Request accepted when high together with a_valid |
| a_opcode | input | 3 | Request opcode |
| a_size | input | 2 | Log2 of transfer bytes |
| a_address | input | ADDR_W | Byte address |
| a_mask | input | 4 | Byte-lane enables |
| a_data | input | 32 | Write data |
| a_source | input | SRC_W | Request tag |
| d_valid | output | 1 | Response valid |
| d_ready | input | 1 | Host accepts response |
| d_opcode | output | 3 | 0 = ack, 1 = ack with data |
| d_size | output | 2 | Echoed size |
| d_source | output | SRC_W | Echoed tag |
| d_data | output | 32 | Read data, zero on error or put |
| d_error | output | 1 | Request broke a rule |
| reg_re | output | 1 | Legal read strobe |
| reg_we | output | 1 | Legal write strobe |
| reg_addr | output | ADDR_W-2 | Word index |
| reg_wdata | output | 32 | Write data to register file |
| reg_rdata | input | 32 | Word read from register file at reg_addr |

## Verification
The hardest situation to reach is a second request that waits on the A channel while the first response is held by a host that is not ready. In that situation the stall must suppress strobes and freeze the response, and releasing `d_ready` must retire one response and accept the next on the same edge. The bench creates this by dropping `d_ready` before a read, then presenting a different read while the first response is pending, then raising `d_ready` again. Every other rule check is driven so that, where the rules allow, only one rule is broken at a time. Each erroneous write is followed by a legal read of the same word, which shows at the ports that the word did not change.

// File: rtl/tlchk_pkg.sv
`timescale 1ns/1ps
package tlchk_pkg;

    localparam logic [2:0] A_PUT_FULL = 3'd0;
    localparam logic [2:0] A_PUT_PART = 3'd1;
    localparam logic [2:0] A_GET      = 3'd4;

    localparam logic [2:0] D_ACK      = 3'd0;
    localparam logic [2:0] D_ACK_DATA = 3'd1;

    typedef struct packed {
        logic bad_op;
        logic full_mask;
        logic lane;
        logic misalign;
        logic size_big;
    } proto_err_t;

    typedef struct packed {
        logic unmapped;
        logic subword;
        logic ro_write;
        logic wo_read;
    } map_err_t;

    typedef struct packed {
        logic        err;
        logic [2:0]  op;
        logic [1:0]  size;
        logic [31:0] data;
    } rsp_t;

    // Byte lanes a transfer of the given size may touch at this offset.
    function automatic logic [3:0] lane_window(logic [1:0] size, logic [1:0] off);
        logic [3:0] w;
        case (size)
            2'd0:    w = 4'b0001 << off;
            2'd1:    w = off[1] ? 4'b1100 : 4'b0011;
            default: w = 4'b1111;
        endcase
        return w;
    endfunction

    function automatic logic op_is_put(logic [2:0] op);
        return (op == A_PUT_FULL) || (op == A_PUT_PART);
    endfunction

    function automatic logic op_is_get(logic [2:0] op);
        return op == A_GET;
    endfunction

endpackage

// File: rtl/tlchk_proto.sv
`timescale 1ns/1ps
module tlchk_proto
    import tlchk_pkg::*;
(
    input  logic [2:0]  opcode,
    input  logic [1:0]  size,
    input  logic [1:0]  addr_lo,
    input  logic [3:0]  mask,
    output proto_err_t  perr
);

    logic [3:0] window;

    always_comb begin
        window         = lane_window(size, addr_lo);
        perr.bad_op    = !(op_is_get(opcode) || op_is_put(opcode));
        perr.full_mask = (opcode == A_PUT_FULL) && (mask != window);
        perr.lane      = |(mask & ~window);
        perr.misalign  = ((size == 2'd1) && addr_lo[0]) ||
                         ((size == 2'd2) && (addr_lo != 2'b00));
        perr.size_big  = (size == 2'd3);
    end

endmodule

// File: rtl/tlchk_map.sv
`timescale 1ns/1ps
module tlchk_map
    import tlchk_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2,
    parameter int NUM_WO = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             is_read,
    input  logic             is_write,
    input  logic [1:0]       addr_lo,
    input  logic [3:0]       mask,
    output map_err_t         merr
);

    localparam int TOTAL  = NUM_RW + NUM_RO + NUM_WO;
    localparam int RO_END = NUM_RW + NUM_RO;

    logic [TOTAL-1:0] hit;
    logic [TOTAL-1:0] ro_hit;
    logic [TOTAL-1:0] wo_hit;

    for (genvar i = 0; i < TOTAL; i++) begin : g_word
        localparam bit WORD_RO = (i >= NUM_RW) && (i < RO_END);
        localparam bit WORD_WO = (i >= RO_END);
        assign hit[i]    = (idx == IDX_W'(i));
        assign ro_hit[i] = hit[i] & WORD_RO;
        assign wo_hit[i] = hit[i] & WORD_WO;
    end

    always_comb begin
        merr.unmapped = ~|hit;
        merr.subword  = is_write && ((addr_lo != 2'b00) || (mask != 4'b1111));
        merr.ro_write = is_write && |ro_hit;
        merr.wo_read  = is_read  && |wo_hit;
    end

endmodule

// File: rtl/tlchk_rsp.sv
`timescale 1ns/1ps
module tlchk_rsp
    import tlchk_pkg::*;
#(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  rsp_t             load_rsp,
    input  logic [SRC_W-1:0] load_src,
    input  logic             d_ready,
    output logic             can_take,
    output logic             d_valid,
    output rsp_t             rsp_q,
    output logic [SRC_W-1:0] src_q
);

    // A new request may enter when the slot is empty or is emptied this cycle.
    assign can_take = !d_valid || d_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid <= 1'b0;
            rsp_q   <= '0;
            src_q   <= '0;
        end else if (load) begin
            d_valid <= 1'b1;
            rsp_q   <= load_rsp;
            src_q   <= load_src;
        end else if (d_ready) begin
            d_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tlchk_dev.sv
`timescale 1ns/1ps
module tlchk_dev
    import tlchk_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SRC_W  = 4,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2,
    parameter int NUM_WO = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [2:0]        a_opcode,
    input  logic [1:0]        a_size,
    input  logic [ADDR_W-1:0] a_address,
    input  logic [3:0]        a_mask,
    input  logic [31:0]       a_data,
    input  logic [SRC_W-1:0]  a_source,
    output logic              d_valid,
    input  logic              d_ready,
    output logic [2:0]        d_opcode,
    output logic [1:0]        d_size,
    output logic [SRC_W-1:0]  d_source,
    output logic [31:0]       d_data,
    output logic              d_error,
    output logic              reg_re,
    output logic              reg_we,
    output logic [ADDR_W-3:0] reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);

    localparam int IDX_W = ADDR_W - 2;

    proto_err_t perr;
    map_err_t   merr;
    rsp_t       rsp_next;
    rsp_t       rsp_q;
    logic       a_fire;
    logic       is_get;
    logic       is_put;
    logic       any_err;

    assign is_get   = op_is_get(a_opcode);
    assign is_put   = op_is_put(a_opcode);
    assign a_fire   = a_valid && a_ready;
    assign reg_addr = a_address[ADDR_W-1:2];

    tlchk_proto u_proto (
        .opcode  (a_opcode),
        .size    (a_size),
        .addr_lo (a_address[1:0]),
        .mask    (a_mask),
        .perr    (perr)
    );

    tlchk_map #(
        .IDX_W  (IDX_W),
        .NUM_RW (NUM_RW),
        .NUM_RO (NUM_RO),
        .NUM_WO (NUM_WO)
    ) u_map (
        .idx      (a_address[ADDR_W-1:2]),
        .is_read  (is_get),
        .is_write (is_put),
        .addr_lo  (a_address[1:0]),
        .mask     (a_mask),
        .merr     (merr)
    );

    always_comb begin
        any_err = perr.bad_op | perr.full_mask | perr.lane | perr.misalign |
                  perr.size_big | merr.unmapped | merr.subword |
                  merr.ro_write | merr.wo_read;
        reg_re    = a_fire && is_get && !any_err;
        reg_we    = a_fire && is_put && !any_err;
        reg_wdata = a_data;
        rsp_next.err  = any_err;
        rsp_next.op   = is_get ? D_ACK_DATA : D_ACK;
        rsp_next.size = a_size;
        rsp_next.data = (is_get && !any_err) ? reg_rdata : 32'h0;
    end

    tlchk_rsp #(
        .SRC_W (SRC_W)
    ) u_rsp (
        .clk      (clk),
        .rst      (rst),
        .load     (a_fire),
        .load_rsp (rsp_next),
        .load_src (a_source),
        .d_ready  (d_ready),
        .can_take (a_ready),
        .d_valid  (d_valid),
        .rsp_q    (rsp_q),
        .src_q    (d_source)
    );

    assign d_opcode = rsp_q.op;
    assign d_size   = rsp_q.size;
    assign d_data   = rsp_q.data;
    assign d_error  = rsp_q.err;

endmodule

// File: rtl/tlchk_sva.sv
`timescale 1ns/1ps
module tlchk_sva #(
    parameter int ADDR_W = 10,
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 2,
    parameter int NUM_WO = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              a_valid,
    input logic              a_ready,
    input logic [2:0]        a_opcode,
    input logic [1:0]        a_size,
    input logic [ADDR_W-1:0] a_address,
    input logic              d_valid,
    input logic              d_ready,
    input logic [31:0]       d_data,
    input logic              d_error,
    input logic              reg_re,
    input logic              reg_we
);

    localparam int TOTAL = NUM_RW + NUM_RO + NUM_WO;

    logic fire;
    assign fire = a_valid && a_ready;

    p_bad_op_r1: assert property (@(posedge clk) disable iff (rst)
        fire && !(a_opcode == 3'd0 || a_opcode == 3'd1 || a_opcode == 3'd4) |=> d_error);

    p_size_big_r4: assert property (@(posedge clk) disable iff (rst)
        fire && (a_size == 2'd3) |=> d_error);

    p_unmapped_r5: assert property (@(posedge clk) disable iff (rst)
        fire && (int'(a_address[ADDR_W-1:2]) >= TOTAL) |=> d_error);

    p_strobe_needs_fire_r8: assert property (@(posedge clk) disable iff (rst)
        !fire |-> !reg_we && !reg_re);

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    p_rsp_after_fire_r9: assert property (@(posedge clk) disable iff (rst)
        fire |=> d_valid);

    p_err_zero_data_r10: assert property (@(posedge clk) disable iff (rst)
        d_valid && d_error |-> d_data == 32'h0);

    p_stall_r11: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_ready |-> !a_ready);

    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_ready |=> d_valid && $stable(d_data) && $stable(d_error));

endmodule

bind tlchk_dev tlchk_sva #(
    .ADDR_W (ADDR_W),
    .NUM_RW (NUM_RW),
    .NUM_RO (NUM_RO),
    .NUM_WO (NUM_WO)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .a_valid   (a_valid),
    .a_ready   (a_ready),
    .a_opcode  (a_opcode),
    .a_size    (a_size),
    .a_address (a_address),
    .d_valid   (d_valid),
    .d_ready   (d_ready),
    .d_data    (d_data),
    .d_error   (d_error),
    .reg_re    (reg_re),
    .reg_we    (reg_we)
);

// File: tb/tlchk_dev_test.sv
`timescale 1ns/1ps
module tlchk_dev_test;

    localparam int ADDR_W = 10;
    localparam int SRC_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              a_valid = 1'b0;
    logic              a_ready;
    logic [2:0]        a_opcode = 3'd4;
    logic [1:0]        a_size = 2'd2;
    logic [ADDR_W-1:0] a_address = '0;
    logic [3:0]        a_mask = 4'hF;
    logic [31:0]       a_data = '0;
    logic [SRC_W-1:0]  a_source = '0;
    logic              d_valid;
    logic              d_ready = 1'b1;
    logic [2:0]        d_opcode;
    logic [1:0]        d_size;
    logic [SRC_W-1:0]  d_source;
    logic [31:0]       d_data;
    logic              d_error;
    logic              reg_re;
    logic              reg_we;
    logic [ADDR_W-3:0] reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;

    logic [31:0] regs [0:255];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    tlchk_dev #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) uut (
        .clk(clk), .rst(rst), .a_valid(a_valid), .a_ready(a_ready),
        .a_opcode(a_opcode), .a_size(a_size), .a_address(a_address),
        .a_mask(a_mask), .a_data(a_data), .a_source(a_source),
        .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
        .d_size(d_size), .d_source(d_source), .d_data(d_data),
        .d_error(d_error), .reg_re(reg_re), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register file model driven only by the strobes.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) regs[i] <= 32'hC0DE_0000 | i;
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = regs[reg_addr];

    function automatic logic [31:0] init_val(int i);
        return 32'hC0DE_0000 | i;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One full request/response with d_ready held high.
    task automatic xfer(string tag, logic [2:0] op, logic [ADDR_W-1:0] addr,
                        logic [1:0] size, logic [3:0] mask, logic [31:0] wdata,
                        logic exp_err, logic [31:0] exp_data);
        logic exp_re, exp_we;
        exp_re = (op == 3'd4) && !exp_err;
        exp_we = (op == 3'd0 || op == 3'd1) && !exp_err;
        @(negedge clk);
        a_valid = 1'b1; a_opcode = op; a_address = addr; a_size = size;
        a_mask = mask; a_data = wdata; a_source = a_source + 1'b1;
        #1;
        chk({tag, " a_ready R11"}, 32'(a_ready), 32'd1);
        chk({tag, " strobes R8"}, {30'd0, reg_re, reg_we}, {30'd0, exp_re, exp_we});
        @(negedge clk);
        a_valid = 1'b0;
        chk({tag, " d_valid R9"}, 32'(d_valid), 32'd1);
        chk({tag, " d_error"}, 32'(d_error), 32'(exp_err));
        chk({tag, " d_data R10"}, d_data, exp_data);
        chk({tag, " d_opcode R9"}, 32'(d_opcode), (op == 3'd4) ? 32'd1 : 32'd0);
        chk({tag, " d_source R9"}, 32'(d_source), 32'(a_source));
        chk({tag, " d_size R9"}, 32'(d_size), 32'(size));
    endtask

    task automatic t_reset;
        chk("reset d_valid R9", 32'(d_valid), 32'd0);
        chk("reset a_ready R11", 32'(a_ready), 32'd1);
        chk("reset strobes R8", {30'd0, reg_re, reg_we}, 32'd0);
    endtask

    task automatic t_legal;
        xfer("R8 putfull rw2", 3'd0, 10'h008, 2'd2, 4'hF, 32'h1234_5678, 1'b0, 32'h0);
        xfer("R10 get rw2", 3'd4, 10'h008, 2'd2, 4'hF, 32'h0, 1'b0, 32'h1234_5678);
        xfer("R8 putpart rw1", 3'd1, 10'h004, 2'd2, 4'hF, 32'hAABB_CCDD, 1'b0, 32'h0);
        xfer("R10 byte get rw2", 3'd4, 10'h009, 2'd0, 4'b0010, 32'h0, 1'b0, 32'h1234_5678);
        xfer("R10 half get rw1", 3'd4, 10'h006, 2'd1, 4'b1100, 32'h0, 1'b0, 32'hAABB_CCDD);
    endtask

    task automatic t_opcode;
        xfer("R1 op2", 3'd2, 10'h008, 2'd2, 4'hF, 32'hDEAD_0001, 1'b1, 32'h0);
        xfer("R1 op7", 3'd7, 10'h008, 2'd2, 4'hF, 32'hDEAD_0002, 1'b1, 32'h0);
        xfer("R1 op5", 3'd5, 10'h000, 2'd2, 4'hF, 32'h0, 1'b1, 32'h0);
        xfer("R1 R8 rw2 unchanged", 3'd4, 10'h008, 2'd2, 4'hF, 32'h0, 1'b0, 32'h1234_5678);
    endtask

    task automatic t_mask;
        xfer("R2 putfull short mask", 3'd0, 10'h000, 2'd2, 4'b0111, 32'hDEAD_0003, 1'b1, 32'h0);
        xfer("R2 rw0 unchanged", 3'd4, 10'h000, 2'd2, 4'hF, 32'h0, 1'b0, init_val(0));
        xfer("R3 lane vs size", 3'd4, 10'h000, 2'd0, 4'b0010, 32'h0, 1'b1, 32'h0);
        xfer("R3 lane vs addr", 3'd4, 10'h001, 2'd0, 4'b0001, 32'h0, 1'b1, 32'h0);
        xfer("R3 half upper lanes ok", 3'd4, 10'h002, 2'd1, 4'b1100, 32'h0, 1'b0, init_val(0));
    endtask

    task automatic t_align;
        xfer("R4 half odd addr", 3'd4, 10'h001, 2'd1, 4'b0010, 32'h0, 1'b1, 32'h0);
        xfer("R4 word at offset 2", 3'd4, 10'h002, 2'd2, 4'b1100, 32'h0, 1'b1, 32'h0);
        xfer("R4 size 3", 3'd4, 10'h000, 2'd3, 4'hF, 32'h0, 1'b1, 32'h0);
    endtask

    task automatic t_unmapped;
        xfer("R5 first unmapped", 3'd4, 10'h020, 2'd2, 4'hF, 32'h0, 1'b1, 32'h0);
        xfer("R5 top write", 3'd0, 10'h3FC, 2'd2, 4'hF, 32'hDEAD_0004, 1'b1, 32'h0);
        xfer("R5 last ro mapped", 3'd4, 10'h014, 2'd2, 4'hF, 32'h0, 1'b0, init_val(5));
    endtask

    task automatic t_subword;
        xfer("R6 partial mask", 3'd1, 10'h00C, 2'd2, 4'b0011, 32'hDEAD_0005, 1'b1, 32'h0);
        xfer("R6 byte write", 3'd1, 10'h00F, 2'd0, 4'b1000, 32'hDEAD_0006, 1'b1, 32'h0);
        xfer("R6 rw3 unchanged", 3'd4, 10'h00C, 2'd2, 4'hF, 32'h0, 1'b0, init_val(3));
    endtask

    task automatic t_policy;
        xfer("R7 write ro4", 3'd0, 10'h010, 2'd2, 4'hF, 32'hDEAD_0007, 1'b1, 32'h0);
        xfer("R7 ro4 unchanged", 3'd4, 10'h010, 2'd2, 4'hF, 32'h0, 1'b0, init_val(4));
        xfer("R7 read wo6", 3'd4, 10'h018, 2'd2, 4'hF, 32'h0, 1'b1, 32'h0);
        xfer("R7 write wo7 ok", 3'd0, 10'h01C, 2'd2, 4'hF, 32'h0F0F_0F0F, 1'b0, 32'h0);
    endtask

    task automatic t_stall;
        @(negedge clk);
        d_ready = 1'b0;
        a_valid = 1'b1; a_opcode = 3'd4; a_address = 10'h008; a_size = 2'd2;
        a_mask = 4'hF; a_source = 4'd9;
        @(negedge clk);
        a_address = 10'h004; a_source = 4'd10;
        #1;
        chk("R11 first rsp valid", 32'(d_valid), 32'd1);
        chk("R11 a_ready low", 32'(a_ready), 32'd0);
        chk("R11 R8 no strobe while stalled", {30'd0, reg_re, reg_we}, 32'd0);
        @(negedge clk);
        chk("R11 still stalled", 32'(a_ready), 32'd0);
        chk("R11 held data", d_data, 32'h1234_5678);
        chk("R11 held source", 32'(d_source), 32'd9);
        d_ready = 1'b1;
        #1;
        chk("R11 ready on release", 32'(a_ready), 32'd1);
        chk("R11 strobe on release", 32'(reg_re), 32'd1);
        @(negedge clk);
        a_valid = 1'b0;
        chk("R11 second rsp valid", 32'(d_valid), 32'd1);
        chk("R11 second data", d_data, 32'hAABB_CCDD);
        chk("R11 second source", 32'(d_source), 32'd10);
        @(negedge clk);
        chk("R9 rsp retired", 32'(d_valid), 32'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_legal();
        t_opcode();
        t_mask();
        t_align();
        t_unmapped();
        t_subword();
        t_policy();
        t_stall();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule